// File: doc/BRIEF.md
# Two-Bank Collapsing Fetch Packer

This block forms one fetch packet per cycle out of two cache-bank reads that arrive together. Each bank delivers a line of four instructions. A one-bit order select, produced by the interleaved branch-target lookup, says which bank holds the line that comes first on the predicted path. An interchange stage puts the two lines into predicted program order. That gives eight candidate instructions in order.

A keep mask, one bit per candidate and derived from branch prediction, marks the instructions on the predicted path. The collapsing stage drops every candidate whose bit is clear, for example the instructions skipped by a taken branch inside a line. It moves the survivors down to the lowest output slots without changing their relative order. The packet comes out with a per-slot valid vector and a count.

Inputs are captured into a register stage. The switch and the compactor are purely combinational between that stage and a registered output packet, so one packet may enter every cycle. Reset is asynchronous and active low, and its release is synchronised internally.

Top module: `cfb_top`

## Requirements
- R1: While reset is held, and on the first edges after it, pkt_valid_o is 0, slot_count_o is 0, slot_valid_o is all zeros and pkt_insn_o is all zeros.
- R2: A packet presented with pkt_valid_i high before rising edge N is captured at N. Its result appears on the outputs after rising edge N+1, and one packet may be presented every cycle.
- R3: With order_sel_i = 0, bank0 lanes 0..3 become predicted positions 0..3 and bank1 lanes 0..3 become positions 4..7. With order_sel_i = 1, bank1 fills positions 0..3 and bank0 fills positions 4..7. Lane k of a bank sits at bits [k*32 +: 32].
- R4: Bit i of path_mask_i (bit 0 = predicted position 0) keeps the instruction at position i. A position whose bit is 0 never appears in the packet.
- R5: Kept instructions occupy output slots 0, 1, 2, ... in increasing predicted position, with no gaps. Slot j is pkt_insn_o[j*32 +: 32].
- R6: slot_count_o equals the number of set bits in path_mask_i (0 to 8). slot_valid_o bit j is 1 exactly when j < slot_count_o.
- R7: Every slot at or above slot_count_o carries all-zero instruction data.
- R8: A valid packet with an all-zero mask produces pkt_valid_o = 1, slot_count_o = 0 and all slots empty.
- R9: A cycle with pkt_valid_i low produces pkt_valid_o = 0, slot_count_o = 0, slot_valid_o = 0 and zero data, whatever the banks, select and mask carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid_i | input | 1 | A packet is presented this cycle |
| bank0_insn_i | input | 128 | Four instructions read from bank 0 |
| bank1_insn_i | input | 128 | Four instructions read from bank 1 |
| order_sel_i | input | 1 | 1 puts the bank 1 line first in predicted order |
| path_mask_i | input | 8 | Keep bit per predicted position |
| pkt_valid_o | output | 1 | Output packet is valid |
| pkt_insn_o | output | 256 | Compacted instructions, slot 0 in the low bits |
| slot_valid_o | output | 8 | Per-slot valid, packed from slot 0 |
| slot_count_o | output | 4 | Number of valid slots |

## Verification
The bench targets the order select with masks that cross the bank boundary. A switch wired the wrong way round would put the second line ahead of the first. The example mask that keeps positions 0, 1, 2, 4 and 6 checks that holes are closed without reordering. A rank off by one would duplicate or lose an instruction. The single-bit masks at positions 0 and 7, the full mask and the empty mask check both ends of the count range and the zero tail above it. Idle cycles with junk on the data inputs check that a dropped valid strobe never leaks stale or fresh data into the packet. Pseudo-random masks and selects, sent back to back, check that the design accepts one packet every cycle.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

  typedef enum logic {
    ORDER_BANK0_FIRST = 1'b0,
    ORDER_BANK1_FIRST = 1'b1
  } order_e;

endpackage

// File: rtl/cfb_rst_sync.sv
module cfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cfb_interchange.sv
module cfb_interchange
  import cfb_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int INSN_W = 32
) (
  input  logic [LANES*INSN_W-1:0]   bank0_i,
  input  logic [LANES*INSN_W-1:0]   bank1_i,
  input  order_e                    order_i,
  output logic [2*LANES*INSN_W-1:0] stream_o
);

  localparam int LINE_W = LANES * INSN_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (order_i == ORDER_BANK1_FIRST) begin
        stream_o[k*INSN_W +: INSN_W]          = bank1_i[k*INSN_W +: INSN_W];
        stream_o[LINE_W + k*INSN_W +: INSN_W] = bank0_i[k*INSN_W +: INSN_W];
      end else begin
        stream_o[k*INSN_W +: INSN_W]          = bank0_i[k*INSN_W +: INSN_W];
        stream_o[LINE_W + k*INSN_W +: INSN_W] = bank1_i[k*INSN_W +: INSN_W];
      end
    end
  end

endmodule

// File: rtl/cfb_rank.sv
module cfb_rank #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]    keep_i,
  output logic [N*CW-1:0] rank_o,
  output logic [CW-1:0]   total_o
);

  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      rank_o[i*CW +: CW] = acc;
      acc = acc + CW'(keep_i[i]);
    end
    total_o = acc;
  end

endmodule

// File: rtl/cfb_collapse.sv
module cfb_collapse #(
  parameter int N      = 8,
  parameter int INSN_W = 32,
  parameter int CW     = $clog2(N + 1)
) (
  input  logic [N*INSN_W-1:0] stream_i,
  input  logic [N-1:0]        keep_i,
  output logic [N*INSN_W-1:0] packed_o,
  output logic [N-1:0]        slot_vld_o,
  output logic [CW-1:0]       count_o
);

  logic [N*CW-1:0] rank;

  cfb_rank #(.N(N), .CW(CW)) u_rank (
    .keep_i  (keep_i),
    .rank_o  (rank),
    .total_o (count_o)
  );

  for (genvar j = 0; j < N; j++) begin : g_slot
    always_comb begin
      logic [INSN_W-1:0] pick;
      pick = '0;
      for (int i = j; i < N; i++) begin
        if (keep_i[i] && (rank[i*CW +: CW] == CW'(j))) begin
          pick = pick | stream_i[i*INSN_W +: INSN_W];
        end
      end
      packed_o[j*INSN_W +: INSN_W] = pick;
    end
    assign slot_vld_o[j] = (CW'(j) < count_o);
  end

endmodule

// File: rtl/cfb_top.sv
module cfb_top
  import cfb_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int INSN_W = 32,
  localparam int N     = 2 * LANES,
  localparam int CW    = $clog2(N + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_valid_i,
  input  logic [LANES*INSN_W-1:0] bank0_insn_i,
  input  logic [LANES*INSN_W-1:0] bank1_insn_i,
  input  logic                  order_sel_i,
  input  logic [N-1:0]          path_mask_i,
  output logic                  pkt_valid_o,
  output logic [N*INSN_W-1:0]   pkt_insn_o,
  output logic [N-1:0]          slot_valid_o,
  output logic [CW-1:0]         slot_count_o
);

  logic rst_q_n;

  cfb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // capture stage
  logic                    cap_vld_q;
  logic [LANES*INSN_W-1:0] cap_b0_q, cap_b1_q;
  logic                    cap_sel_q;
  logic [N-1:0]            cap_mask_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cap_vld_q <= 1'b0;
    end else begin
      cap_vld_q <= pkt_valid_i;
    end
  end

  always_ff @(posedge clk) begin
    if (pkt_valid_i) begin
      cap_b0_q   <= bank0_insn_i;
      cap_b1_q   <= bank1_insn_i;
      cap_sel_q  <= order_sel_i;
      cap_mask_q <= path_mask_i;
    end
  end

  // switch and compactor
  logic [N*INSN_W-1:0] stream, packed_w;
  logic [N-1:0]        slot_vld_w;
  logic [CW-1:0]       count_w;

  cfb_interchange #(.LANES(LANES), .INSN_W(INSN_W)) u_xchg (
    .bank0_i  (cap_b0_q),
    .bank1_i  (cap_b1_q),
    .order_i  (order_e'(cap_sel_q)),
    .stream_o (stream)
  );

  cfb_collapse #(.N(N), .INSN_W(INSN_W), .CW(CW)) u_coll (
    .stream_i   (stream),
    .keep_i     (cap_mask_q),
    .packed_o   (packed_w),
    .slot_vld_o (slot_vld_w),
    .count_o    (count_w)
  );

  // output stage: next state
  logic                nxt_vld;
  logic [N*INSN_W-1:0] nxt_insn;
  logic [N-1:0]        nxt_slot;
  logic [CW-1:0]       nxt_cnt;

  always_comb begin
    nxt_vld  = cap_vld_q;
    nxt_insn = '0;
    nxt_slot = '0;
    nxt_cnt  = '0;
    if (cap_vld_q) begin
      nxt_insn = packed_w;
      nxt_slot = slot_vld_w;
      nxt_cnt  = count_w;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pkt_valid_o  <= 1'b0;
      pkt_insn_o   <= '0;
      slot_valid_o <= '0;
      slot_count_o <= '0;
    end else begin
      pkt_valid_o  <= nxt_vld;
      pkt_insn_o   <= nxt_insn;
      slot_valid_o <= nxt_slot;
      slot_count_o <= nxt_cnt;
    end
  end

  // assertions
  p_count_pop_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    slot_count_o == CW'($countones(slot_valid_o)));

  p_packed_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((slot_valid_o + N'(1)) & slot_valid_o) == '0);

  p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pkt_valid_o |-> (slot_count_o == '0 && pkt_insn_o == '0));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    cap_vld_q |=> pkt_valid_o);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    slot_count_o <= CW'(N));

  for (genvar j = 0; j < N; j++) begin : g_chk
    p_zero_tail_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
      !slot_valid_o[j] |-> pkt_insn_o[j*INSN_W +: INSN_W] == '0);
  end

endmodule

// File: tb/sim_cfb_top.sv
module sim_cfb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 32;
  localparam int LN = 4;
  localparam int NS = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pkt_valid_i;
  logic [LN*IW-1:0]  bank0_insn_i, bank1_insn_i;
  logic              order_sel_i;
  logic [NS-1:0]     path_mask_i;
  logic              pkt_valid_o;
  logic [NS*IW-1:0]  pkt_insn_o;
  logic [NS-1:0]     slot_valid_o;
  logic [3:0]        slot_count_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfb_top u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .pkt_valid_i  (pkt_valid_i),
    .bank0_insn_i (bank0_insn_i),
    .bank1_insn_i (bank1_insn_i),
    .order_sel_i  (order_sel_i),
    .path_mask_i  (path_mask_i),
    .pkt_valid_o  (pkt_valid_o),
    .pkt_insn_o   (pkt_insn_o),
    .slot_valid_o (slot_valid_o),
    .slot_count_o (slot_count_o)
  );

  typedef struct {
    logic             vld;
    logic [3:0]       cnt;
    logic [NS-1:0]    sv;
    logic [NS*IW-1:0] data;
    string            req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  logic [31:0] lf = 32'h1ACE_B00C;

  function automatic logic [LN*IW-1:0] mk_line(input logic [7:0] bank, input logic [15:0] tag);
    logic [LN*IW-1:0] l;
    for (int k = 0; k < LN; k++) l[k*IW +: IW] = {bank, 8'(k), tag};
    return l;
  endfunction

  task automatic send(input logic v, input logic [LN*IW-1:0] b0, input logic [LN*IW-1:0] b1,
                      input logic sel, input logic [NS-1:0] m, input string req);
    exp_t e;
    logic [IW-1:0] ord [NS];
    int c;
    @(negedge clk);
    pkt_valid_i  = v;
    bank0_insn_i = b0;
    bank1_insn_i = b1;
    order_sel_i  = sel;
    path_mask_i  = m;
    for (int k = 0; k < LN; k++) begin
      ord[k]      = sel ? b1[k*IW +: IW] : b0[k*IW +: IW];
      ord[k + LN] = sel ? b0[k*IW +: IW] : b1[k*IW +: IW];
    end
    e.vld = v; e.cnt = '0; e.sv = '0; e.data = '0; e.req = req;
    if (v) begin
      c = 0;
      for (int i = 0; i < NS; i++) begin
        if (m[i]) begin
          e.data[c*IW +: IW] = ord[i];
          e.sv[c] = 1'b1;
          c++;
        end
      end
      e.cnt = 4'(c);
    end
    q.push_back(e);
  endtask

  task automatic chk(input string req, input string what, input logic [NS*IW-1:0] act, input logic [NS*IW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compares the packet driven two negedges earlier
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() >= 2) begin
        exp_t e;
        e = q.pop_front();
        chk({e.req, "/R2"}, "pkt_valid", NS*IW'(pkt_valid_o), NS*IW'(e.vld));
        chk({e.req, "/R6"}, "count", NS*IW'(slot_count_o), NS*IW'(e.cnt));
        chk({e.req, "/R6"}, "slot_valid", NS*IW'(slot_valid_o), NS*IW'(e.sv));
        chk({e.req, "/R5/R7"}, "data", pkt_insn_o, e.data);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [LN*IW-1:0] a, b;
    rst_n = 1'b0;
    pkt_valid_i = 1'b0;
    bank0_insn_i = '1;
    bank1_insn_i = '1;
    order_sel_i = 1'b0;
    path_mask_i = '1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R1: outputs cleared in reset
    chk("R1", "reset valid", NS*IW'(pkt_valid_o), '0);
    chk("R1", "reset count", NS*IW'(slot_count_o), '0);
    chk("R1", "reset slots", NS*IW'(slot_valid_o), '0);
    chk("R1", "reset data", pkt_insn_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1", "post-reset valid", NS*IW'(pkt_valid_o), '0);
    repeat (3) @(negedge clk);

    a = mk_line(8'hA0, 16'h0001);
    b = mk_line(8'hB0, 16'h0001);
    send(1, a, b, 0, 8'hFF, "R3");           // full, bank0 first
    send(1, a, b, 1, 8'hFF, "R3");           // full, bank1 first
    send(1, a, b, 0, 8'b0101_0111, "R4");    // keep 0,1,2,4,6
    send(1, a, b, 1, 8'b0101_0111, "R4");
    send(1, a, b, 0, 8'h00, "R8");           // empty packet
    send(1, a, b, 0, 8'h01, "R6");           // only position 0
    send(1, a, b, 1, 8'h80, "R6");           // only position 7
    send(1, a, b, 0, 8'hAA, "R5");
    send(1, a, b, 1, 8'h55, "R5");
    send(1, a, b, 0, 8'hF0, "R3");           // second line only
    send(0, '1, '1, 1, 8'hFF, "R9");         // idle with junk
    send(1, a, b, 1, 8'h0F, "R3");
    send(0, '0, '1, 0, 8'h3C, "R9");
    send(0, '1, '0, 1, 8'hC3, "R9");
    send(1, a, b, 0, 8'h18, "R4");
    for (int n = 0; n < 60; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      send(lf[12] | lf[13], mk_line(8'hA0, lf[31:16]), mk_line(8'hB0, lf[15:0]),
           lf[3], lf[11:4], "R2");
    end
    send(0, '0, '0, 0, '0, "R9");
    send(0, '0, '0, 0, '0, "R9");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule